// File: doc/BRIEF.md
# Serial EEPROM Write-Mode Engine

This block is the byte-level write path of a small serial EEPROM holding 256 bytes arranged as rows of 8. A bit-level two-wire slave front end decodes the line traffic. It hands this engine one strobe per event: bus start, bus stop, a device-select byte already matched for a write, the memory address byte, or a data byte. For each strobe the engine returns an acknowledge decision in the same cycle. The engine tracks an internal byte-address pointer and buffers the incoming bytes. When the master issues a stop, the buffered bytes are written into a register-array store in a single cycle. A programming interval then follows, and for its whole length the engine answers nothing.

A mode pin chooses between two ways of advancing the address. In burst mode the pointer walks linearly through the whole array, and at most four bytes are kept. In row mode only the three low pointer bits count, so they wrap inside the row that the address byte selected. The programming interval is a parameterised clock count, and it is doubled when a burst-mode write touches two rows. A combinational observation port exposes the array contents to the read logic, which lives outside this block.

Top module: `eeprom_write_engine`

## Requirements
- R1: After reset, busy_o and ack_o are low and every array byte reads 0.
- R2: The mode pin is sampled when the address byte is acknowledged (1 = burst mode, 0 = row mode). Changing the pin during the data bytes has no effect on that write.
- R3: In burst mode, a write may begin at any address. Data byte k (counting from 0) goes to address (start + k) mod 256, and every data byte is acknowledged.
- R4: In burst mode, data bytes after the fourth are still acknowledged, but they are dropped. The addresses they would have reached keep their old contents.
- R5: After a burst-mode write, busy_o stays high for exactly TW_CYCLES clocks when the first and last stored addresses share bits 7..3. Otherwise it stays high for exactly 2*TW_CYCLES clocks.
- R6: In row mode, data byte k goes to the address whose bits 7..3 match the start address and whose bits 2..0 equal (start[2:0] + k) mod 8. A later byte overwrites an earlier byte that landed at the same address, and every data byte is acknowledged.
- R7: After a row-mode write, busy_o stays high for exactly TW_CYCLES clocks.
- R8: A stop strobe that follows at least one acknowledged data byte writes the buffered bytes at that clock edge. busy_o rises in the next cycle.
- R9: A stop strobe that comes after the address byte with no data byte between them writes nothing and leaves busy_o low.
- R10: While busy_o is high, ack_o stays low. Every strobe and every byte is ignored, so a later stop finds nothing buffered.
- R11: A select byte is acknowledged only while waiting for select. An address byte is acknowledged only directly after an acknowledged select, and a data byte only after an acknowledged address byte. A byte that arrives out of this order gets no acknowledge.
- R12: A start strobe discards any buffered data and returns the engine to waiting for a select byte. A following stop then writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_multi_i | input | 1 | Write mode pin: 1 burst mode, 0 row mode |
| start_i | input | 1 | Bus start (or repeated start) strobe |
| stop_i | input | 1 | Bus stop strobe |
| sel_vld_i | input | 1 | Matched write device-select byte strobe |
| addr_vld_i | input | 1 | Memory address byte strobe |
| addr_i | input | ADDR_W | Memory address byte value |
| data_vld_i | input | 1 | Data byte strobe |
| data_i | input | DATA_W | Data byte value |
| ack_o | output | 1 | Acknowledge decision for the strobe of this cycle |
| busy_o | output | 1 | Programming interval in progress |
| rd_addr_i | input | ADDR_W | Array observation address |
| rd_data_o | output | DATA_W | Array byte at rd_addr_i |

## Verification
The bench builds the engine with TW_CYCLES = 3 and keeps the default 256-byte, 8-byte-row geometry. Because the interval is so short, burst mode can be swept from every one of the 256 start addresses with burst lengths of one to six. Row mode is swept from start offsets that hit every low-bit value, with lengths up to eleven, which forces the pointer to wrap. Every row crossing, the crossing at the top of the address space, the dropped fifth and sixth bytes and all wrap-and-overwrite cases are covered in a modest number of cycles. The short interval also lets the bench drive a full select/address/data sequence while busy_o is high and confirm that nothing is acknowledged.

// File: rtl/eew_pkg.sv
package eew_pkg;

  typedef enum logic [1:0] {
    PH_SEL  = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  // Row index of a byte address.
  function automatic int row_of(input int addr, input int row_bits);
    return addr >> row_bits;
  endfunction

  // Linear pointer step across the whole array.
  function automatic int linear_next(input int addr, input int addr_w);
    return (addr + 1) & ((1 << addr_w) - 1);
  endfunction

  // Pointer step that only moves the low bits and wraps inside the row.
  function automatic int row_wrap_next(input int addr, input int row_bits);
    int mask;
    mask = (1 << row_bits) - 1;
    return (addr & ~mask) | ((addr + 1) & mask);
  endfunction

  // Length of the programming interval.
  function automatic int interval_len(input int tw, input logic two_rows);
    return two_rows ? 2 * tw : tw;
  endfunction

endpackage

// File: rtl/eew_seq.sv
module eew_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic sel_vld_i,
  input  logic addr_vld_i,
  input  logic data_vld_i,
  input  logic has_data_i,
  output logic ack_o,
  output logic take_addr_o,
  output logic take_data_o,
  output logic commit_o,
  output logic flush_o
);
  import eew_pkg::*;

  phase_e phase_q;
  logic   take_sel;

  always_comb begin
    take_sel    = !busy_i && sel_vld_i  && (phase_q == PH_SEL);
    take_addr_o = !busy_i && addr_vld_i && (phase_q == PH_ADDR);
    take_data_o = !busy_i && data_vld_i && (phase_q == PH_DATA);
    ack_o       = take_sel || take_addr_o || take_data_o;
    commit_o    = !busy_i && stop_i && (phase_q == PH_DATA) && has_data_i;
    flush_o     = !busy_i && (start_i || stop_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_SEL;
    end else if (!busy_i) begin
      if (start_i || stop_i)  phase_q <= PH_SEL;
      else if (take_sel)      phase_q <= PH_ADDR;
      else if (take_addr_o)   phase_q <= PH_DATA;
    end
  end

endmodule

// File: rtl/eew_buf.sv
module eew_buf #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int ROW_BITS  = 3,
  parameter int MULTI_MAX = 4,
  localparam int SLOTS    = 1 << ROW_BITS,
  localparam int NB_W     = $clog2(SLOTS + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              mode_i,
  input  logic                              take_addr_i,
  input  logic                              take_data_i,
  input  logic                              flush_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [DATA_W-1:0]                 data_i,
  output logic [SLOTS-1:0]                  slot_valid_o,
  output logic [SLOTS-1:0][ADDR_W-1:0]      slot_addr_o,
  output logic [SLOTS-1:0][DATA_W-1:0]      slot_data_o,
  output logic                              has_data_o,
  output logic                              span_o,
  output logic                              mode_q_o,
  output logic [ADDR_W-1:0]                 ptr_o
);
  import eew_pkg::*;

  logic [NB_W-1:0]                 nbytes_q;
  logic [ADDR_W-1:0]               ptr_q, first_q, last_q;
  logic                            mode_q;
  logic [SLOTS-1:0]                valid_q;
  logic [SLOTS-1:0][ADDR_W-1:0]    addr_q;
  logic [SLOTS-1:0][DATA_W-1:0]    data_q;

  logic                            keep;
  logic [ROW_BITS-1:0]             slot;
  logic [ADDR_W-1:0]               ptr_next;

  always_comb begin
    keep     = !mode_q || (nbytes_q < NB_W'(MULTI_MAX));
    slot     = mode_q ? nbytes_q[ROW_BITS-1:0] : ptr_q[ROW_BITS-1:0];
    ptr_next = mode_q ? ADDR_W'(linear_next(int'(ptr_q), ADDR_W))
                      : ADDR_W'(row_wrap_next(int'(ptr_q), ROW_BITS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbytes_q <= '0;
      ptr_q    <= '0;
      first_q  <= '0;
      last_q   <= '0;
      mode_q   <= 1'b0;
      valid_q  <= '0;
      addr_q   <= '0;
      data_q   <= '0;
    end else if (flush_i) begin
      valid_q  <= '0;
      nbytes_q <= '0;
    end else if (take_addr_i) begin
      ptr_q    <= addr_i;
      first_q  <= addr_i;
      last_q   <= addr_i;
      mode_q   <= mode_i;
      valid_q  <= '0;
      nbytes_q <= '0;
    end else if (take_data_i) begin
      if (keep) begin
        valid_q[slot] <= 1'b1;
        addr_q[slot]  <= ptr_q;
        data_q[slot]  <= data_i;
        last_q        <= ptr_q;
      end
      ptr_q <= ptr_next;
      if (nbytes_q != NB_W'(SLOTS)) nbytes_q <= nbytes_q + 1'b1;
    end
  end

  assign slot_valid_o = valid_q;
  assign slot_addr_o  = addr_q;
  assign slot_data_o  = data_q;
  assign has_data_o   = (nbytes_q != '0);
  assign span_o       = mode_q &&
                        (row_of(int'(first_q), ROW_BITS) != row_of(int'(last_q), ROW_BITS));
  assign mode_q_o     = mode_q;
  assign ptr_o        = ptr_q;

endmodule

// File: rtl/eew_timer.sv
module eew_timer #(
  parameter int  TW_CYCLES = 20,
  localparam int CNT_W     = $clog2(2 * TW_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit_i,
  input  logic two_rows_i,
  output logic busy_o
);
  import eew_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (commit_i)      cnt_q <= CNT_W'(interval_len(TW_CYCLES, two_rows_i));
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/eew_array.sv
module eew_array #(
  parameter int  ADDR_W   = 8,
  parameter int  DATA_W   = 8,
  parameter int  ROW_BITS = 3,
  localparam int SLOTS    = 1 << ROW_BITS,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [SLOTS-1:0]             slot_valid_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0] slot_addr_i,
  input  logic [SLOTS-1:0][DATA_W-1:0] slot_data_i,
  input  logic [ADDR_W-1:0]            rd_addr_i,
  output logic [DATA_W-1:0]            rd_data_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (slot_valid_i[s]) mem_q[slot_addr_i[s]] <= slot_data_i[s];
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/eeprom_write_engine.sv
module eeprom_write_engine #(
  parameter int  ADDR_W    = 8,
  parameter int  DATA_W    = 8,
  parameter int  ROW_BITS  = 3,
  parameter int  MULTI_MAX = 4,
  parameter int  TW_CYCLES = 20,
  localparam int SLOTS     = 1 << ROW_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_multi_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sel_vld_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              busy_o,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);

  // Named internal events, brought out for the bound checker.
  logic                         busy_w;
  logic                         ack_w;
  logic                         take_addr_w;
  logic                         take_data_w;
  logic                         commit_w;
  logic                         flush_w;
  logic                         has_data_w;
  logic                         span_w;
  logic                         mode_q_w;
  logic [ADDR_W-1:0]            ptr_w;
  logic [SLOTS-1:0]             slot_valid_w;
  logic [SLOTS-1:0][ADDR_W-1:0] slot_addr_w;
  logic [SLOTS-1:0][DATA_W-1:0] slot_data_w;

  eew_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy_i      (busy_w),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .sel_vld_i   (sel_vld_i),
    .addr_vld_i  (addr_vld_i),
    .data_vld_i  (data_vld_i),
    .has_data_i  (has_data_w),
    .ack_o       (ack_w),
    .take_addr_o (take_addr_w),
    .take_data_o (take_data_w),
    .commit_o    (commit_w),
    .flush_o     (flush_w)
  );

  eew_buf #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .ROW_BITS  (ROW_BITS),
    .MULTI_MAX (MULTI_MAX)
  ) u_buf (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_multi_i),
    .take_addr_i  (take_addr_w),
    .take_data_i  (take_data_w),
    .flush_i      (flush_w),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .slot_valid_o (slot_valid_w),
    .slot_addr_o  (slot_addr_w),
    .slot_data_o  (slot_data_w),
    .has_data_o   (has_data_w),
    .span_o       (span_w),
    .mode_q_o     (mode_q_w),
    .ptr_o        (ptr_w)
  );

  eew_timer #(
    .TW_CYCLES (TW_CYCLES)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_i   (commit_w),
    .two_rows_i (span_w),
    .busy_o     (busy_w)
  );

  eew_array #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ROW_BITS (ROW_BITS)
  ) u_array (
    .clk          (clk),
    .rst_n        (rst_n),
    .we_i         (commit_w),
    .slot_valid_i (slot_valid_w),
    .slot_addr_i  (slot_addr_w),
    .slot_data_i  (slot_data_w),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o)
  );

  assign ack_o  = ack_w;
  assign busy_o = busy_w;

endmodule

// File: rtl/eew_checker.sv
module eew_checker #(
  parameter int  ADDR_W    = 8,
  parameter int  ROW_BITS  = 3,
  parameter int  MULTI_MAX = 4,
  parameter int  TW_CYCLES = 20,
  localparam int SLOTS     = 1 << ROW_BITS,
  localparam int RUN_W     = $clog2(2 * TW_CYCLES + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ack,
  input logic              commit,
  input logic              span,
  input logic              mode_q,
  input logic              take_data,
  input logic [ADDR_W-1:0] ptr,
  input logic [SLOTS-1:0]  slot_valid,
  input logic              sel_vld,
  input logic              addr_vld,
  input logic              data_vld
);

  logic [RUN_W-1:0] run_q;
  logic             dbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      dbl_q <= 1'b0;
    end else if (commit) begin
      run_q <= '0;
      dbl_q <= span;
    end else if (busy) begin
      run_q <= run_q + 1'b1;
    end
  end

  assert_silent_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ack);

  assert_busy_after_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  assert_busy_needs_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));

  assert_interval_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RUN_W'(dbl_q ? 2 * TW_CYCLES : TW_CYCLES)));

  assert_burst_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> ($countones(slot_valid) <= MULTI_MAX));

  assert_row_pinned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_data && !mode_q) |=> (ptr[ADDR_W-1:ROW_BITS] == $past(ptr[ADDR_W-1:ROW_BITS])));

  assert_ack_needs_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (sel_vld || addr_vld || data_vld));

endmodule

bind eeprom_write_engine eew_checker #(
  .ADDR_W    (ADDR_W),
  .ROW_BITS  (ROW_BITS),
  .MULTI_MAX (MULTI_MAX),
  .TW_CYCLES (TW_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy_w),
  .ack        (ack_w),
  .commit     (commit_w),
  .span       (span_w),
  .mode_q     (mode_q_w),
  .take_data  (take_data_w),
  .ptr        (ptr_w),
  .slot_valid (slot_valid_w),
  .sel_vld    (sel_vld_i),
  .addr_vld   (addr_vld_i),
  .data_vld   (data_vld_i)
);

// File: tb/sim_eeprom_write_engine.sv
`timescale 1ns/1ps
module sim_eeprom_write_engine;
  localparam int TW = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_multi_i = 1'b0;
  logic       start_i = 1'b0, stop_i = 1'b0;
  logic       sel_vld_i = 1'b0, addr_vld_i = 1'b0, data_vld_i = 1'b0;
  logic [7:0] addr_i = '0, data_i = '0, rd_addr_i = '0;
  logic       ack_o, busy_o;
  logic [7:0] rd_data_o;

  always #2 clk = ~clk;

  eeprom_write_engine #(.TW_CYCLES(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_multi_i(mode_multi_i),
    .start_i(start_i), .stop_i(stop_i), .sel_vld_i(sel_vld_i),
    .addr_vld_i(addr_vld_i), .addr_i(addr_i), .data_vld_i(data_vld_i),
    .data_i(data_i), .ack_o(ack_o), .busy_o(busy_o),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
  );

  int         n_chk = 0, n_bad = 0;
  bit         done = 0;
  logic [7:0] model [256];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 start, 1 stop, 2 select, 3 address, 4 data
  task automatic send(input int kind, input int val, output bit ackv);
    @(negedge clk);
    start_i    = (kind == 0);
    stop_i     = (kind == 1);
    sel_vld_i  = (kind == 2);
    addr_vld_i = (kind == 3);
    data_vld_i = (kind == 4);
    if (kind == 3) addr_i = 8'(val);
    if (kind == 4) data_i = 8'(val);
    #1 ackv = ack_o;
    @(posedge clk);
    #1;
    start_i = 0; stop_i = 0; sel_vld_i = 0; addr_vld_i = 0; data_vld_i = 0;
  endtask

  task automatic measure_busy(output int len);
    len = 0;
    @(negedge clk);
    while (busy_o && len < 100) begin
      len++;
      @(negedge clk);
    end
  endtask

  // Compare bytes [base, base+cnt) modulo 256 against the model.
  task automatic compare_window(input int base, input int cnt, input string req);
    int bad_a = -1, act = 0, exp = 0;
    for (int i = 0; i < cnt; i++) begin
      rd_addr_i = 8'(base + i);
      #1;
      if (bad_a < 0 && rd_data_o !== model[(base + i) & 255]) begin
        bad_a = (base + i) & 255; act = rd_data_o; exp = model[bad_a];
      end
    end
    check(bad_a < 0, req, act, exp);
  endtask

  // Select, address and data bytes; updates the model; returns the expected interval.
  task automatic load(input bit mode, input int s, input int n, input int salt,
                      input string req, output int exp_len);
    bit a;
    int kept, last;
    mode_multi_i = mode;
    send(2, 0, a); check(a, "R11 select ack", a, 1);
    send(3, s, a); check(a, "R11 address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      int d = (s * 7 + k * 29 + n * 3 + salt) & 255;
      send(4, d, a); check(a, {req, " data ack"}, a, 1);
      if (mode) begin
        if (k < 4) model[(s + k) & 255] = 8'(d);
      end else begin
        model[(s & ~7) | ((s + k) & 7)] = 8'(d);
      end
    end
    kept = (n < 4) ? n : 4;
    last = (s + kept - 1) & 255;
    exp_len = (mode && ((s >> 3) != (last >> 3))) ? 2 * TW : TW;
  endtask

  task automatic burst(input bit mode, input int s, input int n, input int salt);
    bit a;
    int exp_len, len;
    string req;
    req = mode ? ((n > 4) ? "R4" : "R3") : "R6";
    load(mode, s, n, salt, req, exp_len);
    send(1, 0, a);
    measure_busy(len);
    check(len == exp_len, mode ? "R5 interval" : "R7 interval", len, exp_len);
    compare_window(((s >> 3) - 1) * 8, 24, {req, " array contents"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit a;
    int len, exp_len;
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(busy_o == 0, "R1 busy after reset", busy_o, 0);
    check(ack_o == 0, "R1 ack after reset", ack_o, 0);
    compare_window(0, 256, "R1 array cleared");

    // R11: out-of-order bytes get no acknowledge
    send(3, 5, a); check(!a, "R11 address without select", a, 0);
    send(4, 9, a); check(!a, "R11 data without address", a, 0);
    send(2, 0, a); check(a, "R11 select ack", a, 1);
    send(4, 9, a); check(!a, "R11 data before address", a, 0);
    send(1, 0, a);
    @(negedge clk);
    check(busy_o == 0, "R11 no write after refused bytes", busy_o, 0);

    // R9: stop directly after the address byte
    mode_multi_i = 1;
    send(2, 0, a);
    send(3, 100, a);
    send(1, 0, a);
    measure_busy(len);
    check(len == 0, "R9 empty stop interval", len, 0);
    compare_window(96, 16, "R9 array unchanged");

    // R3/R4/R5: burst mode from every start address, lengths 1..6
    for (int s = 0; s < 256; s++)
      for (int n = 1; n <= 6; n++) burst(1'b1, s, n, 11);

    // R6/R7: row mode, all low-bit offsets, lengths up to 11 (wrap)
    for (int s = 0; s < 256; s += 5)
      for (int n = 1; n <= 11; n++) burst(1'b0, s, n, 37);

    // R2: pin sampled at the address byte; changed afterwards
    mode_multi_i = 0;
    send(2, 0, a);
    send(3, 8'h36, a);
    mode_multi_i = 1;
    send(4, 8'hA1, a); send(4, 8'hA2, a); send(4, 8'hA3, a);
    model[8'h36] = 8'hA1; model[8'h37] = 8'hA2; model[8'h30] = 8'hA3;
    send(1, 0, a);
    measure_busy(len);
    check(len == TW, "R2 latched row mode interval", len, TW);
    compare_window(8'h28, 24, "R2 latched row mode contents");

    // R8 and R10: everything ignored while busy
    load(1'b1, 8'h7E, 3, 5, "R8", exp_len);
    send(1, 0, a);
    check(busy_o == 1, "R8 busy rises after stop", busy_o, 1);
    compare_window(8'h78, 16, "R8 written at stop");
    send(2, 0, a); check(!a, "R10 select while busy", a, 0);
    send(3, 8'h10, a); check(!a, "R10 address while busy", a, 0);
    send(4, 8'h55, a); check(!a, "R10 data while busy", a, 0);
    while (busy_o) @(negedge clk);
    send(1, 0, a);
    measure_busy(len);
    check(len == 0, "R10 nothing buffered during busy", len, 0);
    compare_window(8'h08, 16, "R10 array unchanged");

    // R12: start discards buffered data
    mode_multi_i = 1;
    send(2, 0, a);
    send(3, 40, a);
    send(4, 8'hEE, a); send(4, 8'hEF, a);
    send(0, 0, a);
    send(1, 0, a);
    measure_busy(len);
    check(len == 0, "R12 start discards buffer", len, 0);
    compare_window(32, 24, "R12 array unchanged");
    send(2, 0, a); check(a, "R12 select after start", a, 1);
    send(1, 0, a);

    compare_window(0, 256, "R3 final array");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule